// File: doc/BRIEF.md
# DRAM Data Path Read/Write Controller

This block governs the data pins of an asynchronous dynamic memory. The memory's strobes are sampled on a fast system clock. The block takes the column strobe, the write-enable strobe, the data input, the read data of the selected cell, and two interlock inputs from the array timing sequencer: sensing done and column selected. From these it decides, once per column cycle, whether the data output is driven or left at high impedance. It also decides when input data is captured and written to the array. It handles read, early-write, late-write and read-modify-write cycles.

The output decision is made when the column strobe is low and both interlocks are true. At that point the write-enable level is sampled. A high level enables the output and loads the cell data into the output register. A low level means an early write, and the output stays at high impedance until the column strobe rises again. Input data is captured when the later of the two strobes falls. It is then written with a one-cycle strobe once the interlocks allow it. A valid flag marks the driven output as meaningful only after both the row and the column access delays, counted in clock cycles, have passed.

Top module: `dram_dio_ctrl`

## Requirements
- R1: After reset, and from the first clock edge that finds `cas_n` high, `q_oe` and `q_valid` are 0.
- R2: On the first edge in a column cycle where `cas_n`=0, `sense_done`=1 and `col_sel`=1 all hold, a high `we_n` sets `q_oe`=1 and loads `rd_data` into `q`. Both are visible after that edge.
- R3: If `we_n` is 0 at that decision edge (early write), `q_oe` stays 0 until `cas_n` returns high.
- R4: `q_valid` is 1 only when `q_oe`=1, `ras_n` has been low for at least `T_RAC` edges and `cas_n` has been low for at least `T_CAC` edges. Either delay can be the limiting one.
- R5: While `we_n` is high, no data is captured and `wr_stb` is never raised.
- R6: `din` is captured on the first edge that finds `cas_n` and `we_n` both low, which is the later of the two falls. Later changes of `din` do not alter `wr_data`.
- R7: Each capture produces exactly one single-cycle `wr_stb` pulse, no earlier than the edge after the capture, with `wr_data` equal to the captured value.
- R8: While `q_oe` stays 1, `q` holds the cell data loaded at the decision edge. This holds through changes of `rd_data` and through a write in the same cycle, as in read-modify-write.
- R9: While `sense_done` or `col_sel` is 0, neither the output decision nor the write strobe happens. Both take place after the interlocks become true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| din | input | DW | Data input pins |
| sense_done | input | 1 | Sequencer interlock: sensing complete |
| col_sel | input | 1 | Sequencer interlock: column decoded and selected |
| rd_data | input | DW | Data of the selected cell |
| q | output | DW | Data output register |
| q_oe | output | 1 | Output drive enable (0 = high impedance) |
| q_valid | output | 1 | Output enabled and both access delays met |
| wr_stb | output | 1 | One-cycle write strobe to the array |
| wr_data | output | DW | Captured write data |

## Verification
The bench runs six cycle types: a plain read, a read whose start is limited by the column delay, an early write, a read-modify-write, a late write held back by a low sense-done interlock, and a read held back by a low column-select interlock. The plain read and the column-limited read show which access delay gates the valid flag. The early write and the late write show that the level of write enable at the decision edge alone picks high impedance, even when the write happens after the column strobe falls. The read-modify-write shows that the output keeps the old cell data while the new data is written. Changing `din` after capture, and while write enable is high, shows that data is captured only at the later strobe fall.

// File: rtl/dio_pkg.sv
package dio_pkg;

  // saturating increment used by the access-delay timers
  function automatic int unsigned sat_next(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // output is meaningful only when driven and both delays have elapsed
  function automatic logic access_ready(logic oe, logic row_ok, logic col_ok);
    return oe & row_ok & col_ok;
  endfunction

  // combined sequencer interlock
  function automatic logic interlock_ok(logic sensed, logic selected);
    return sensed & selected;
  endfunction

endpackage

// File: rtl/dio_access_timer.sv
module dio_access_timer #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  generate
    if (LIMIT == 0) begin : g_none
      logic unused_run;
      assign unused_run = run;
      assign done = 1'b1;
    end else begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= CW'(dio_pkg::sat_next(32'(cnt), LIMIT));
      end
      assign done = (32'(cnt) >= LIMIT);
    end
  endgenerate
endmodule

// File: rtl/dio_out_ctrl.sv
module dio_out_ctrl #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          ilk_ok,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] q,
  output logic          oe,
  output logic          decide_evt
);
  logic decided;

  // one decision per column cycle, gated by the interlocks
  assign decide_evt = !cas_n && ilk_ok && !decided;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe      <= 1'b0;
      decided <= 1'b0;
      q       <= '0;
    end else if (cas_n) begin
      oe      <= 1'b0;
      decided <= 1'b0;
    end else if (decide_evt) begin
      decided <= 1'b1;
      oe      <= we_n;
      if (we_n) q <= rd_data;
    end
  end
endmodule

// File: rtl/dio_write_path.sv
module dio_write_path #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          ilk_ok,
  input  logic [DW-1:0] din,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          cap_evt
);
  logic both_low, both_low_q, pending;

  assign both_low = !cas_n && !we_n;
  assign cap_evt  = both_low && !both_low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      both_low_q <= 1'b0;
      pending    <= 1'b0;
      wr_stb     <= 1'b0;
      wr_data    <= '0;
    end else begin
      both_low_q <= both_low;
      wr_stb     <= 1'b0;
      if (cap_evt) begin
        wr_data <= din;
        pending <= 1'b1;
      end else if (cas_n) begin
        pending <= 1'b0;
      end else if (pending && ilk_ok) begin
        wr_stb  <= 1'b1;
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_dio_ctrl.sv
module dram_dio_ctrl #(
  parameter int unsigned DW    = 4,
  parameter int unsigned T_RAC = 6,
  parameter int unsigned T_CAC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [DW-1:0] din,
  input  logic          sense_done,
  input  logic          col_sel,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] q,
  output logic          q_oe,
  output logic          q_valid,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);
  logic ilk_ok, row_ok, col_ok, decide_evt, cap_evt;

  assign ilk_ok = dio_pkg::interlock_ok(sense_done, col_sel);

  dio_access_timer #(.LIMIT(T_RAC)) u_row_tmr (
    .clk(clk), .rst_n(rst_n), .run(!ras_n), .done(row_ok)
  );

  dio_access_timer #(.LIMIT(T_CAC)) u_col_tmr (
    .clk(clk), .rst_n(rst_n), .run(!cas_n), .done(col_ok)
  );

  dio_out_ctrl #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n), .ilk_ok(ilk_ok),
    .rd_data(rd_data), .q(q), .oe(q_oe), .decide_evt(decide_evt)
  );

  dio_write_path #(.DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n), .ilk_ok(ilk_ok),
    .din(din), .wr_stb(wr_stb), .wr_data(wr_data), .cap_evt(cap_evt)
  );

  assign q_valid = dio_pkg::access_ready(q_oe, row_ok, col_ok);
endmodule

// File: rtl/dram_dio_ctrl_chk.sv
module dram_dio_ctrl_chk #(
  parameter int unsigned DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          sense_done,
  input logic          col_sel,
  input logic          q_oe,
  input logic          q_valid,
  input logic [DW-1:0] q,
  input logic          wr_stb,
  input logic          cap_evt
);
  // R1
  a_r1_cas_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !q_oe);
  // R3
  a_r3_enable_needs_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |-> $past(we_n));
  // R4
  a_r4_valid_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> q_oe);
  // R4
  a_r4_valid_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> ($past(!ras_n) && $past(!cas_n)));
  // R8
  a_r8_q_held: assert property (@(posedge clk) disable iff (!rst_n)
    (q_oe && $past(q_oe)) |-> $stable(q));
  // R9
  a_r9_write_interlocked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(sense_done && col_sel));
  // R5
  a_r5_capture_needs_we_low: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> !we_n);
  // R7
  a_r7_no_strobe_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !wr_stb);
endmodule

bind dram_dio_ctrl dram_dio_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .sense_done(sense_done), .col_sel(col_sel), .q_oe(q_oe), .q_valid(q_valid),
  .q(q), .wr_stb(wr_stb), .cap_evt(cap_evt)
);

// File: tb/dram_dio_ctrl_tb.sv
module dram_dio_ctrl_tb;
  localparam int DW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, sense_done = 1'b0, col_sel = 1'b0;
  logic [DW-1:0] din = '0, rd_data = '0;
  logic [DW-1:0] q, wr_data;
  logic q_oe, q_valid, wr_stb;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #10 clk = ~clk;

  dram_dio_ctrl #(.DW(DW), .T_RAC(6), .T_CAC(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .din(din), .sense_done(sense_done), .col_sel(col_sel), .rd_data(rd_data),
    .q(q), .q_oe(q_oe), .q_valid(q_valid), .wr_stb(wr_stb), .wr_data(wr_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_write(logic [DW-1:0] d);
    exp_q.push_back(d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: every write strobe must match a queued item
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected wr_stb", 1, 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check("R6/R7 wr_data", 32'(wr_data), 32'(e));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 reset q_oe", 32'(q_oe), 0);
    check("R1 reset q_valid", 32'(q_valid), 0);
    check("R1 reset wr_stb", 32'(wr_stb), 0);

    // plain read, row delay limits validity
    ras_n = 0; sense_done = 1; col_sel = 1; rd_data = 4'hA; step(1);
    cas_n = 0; step(1);
    check("R2 read q_oe", 32'(q_oe), 1);
    check("R2 read q", 32'(q), 32'hA);
    check("R4 valid early", 32'(q_valid), 0);
    step(3);
    check("R4 valid before row delay", 32'(q_valid), 0);
    step(1);
    check("R4 valid at row delay", 32'(q_valid), 1);
    rd_data = 4'h5; din = 4'h3; step(1); din = 4'h4; step(1);
    check("R8 q held", 32'(q), 32'hA);
    check("R5 no strobe with we high", 32'(wr_stb), 0);
    cas_n = 1; step(1);
    check("R1 cas high q_oe", 32'(q_oe), 0);
    check("R1 cas high q_valid", 32'(q_valid), 0);
    ras_n = 1; step(2);

    // column delay limits validity
    ras_n = 0; step(8);
    cas_n = 0; step(2);
    check("R4 before column delay", 32'(q_valid), 0);
    step(1);
    check("R4 at column delay", 32'(q_valid), 1);
    cas_n = 1; ras_n = 1; step(2);

    // early write
    ras_n = 0; step(1);
    we_n = 0; din = 4'h6; step(1);
    cas_n = 0; push_write(4'h6); step(1);
    check("R7 no strobe at capture", 32'(wr_stb), 0);
    din = 4'h9; step(1);
    check("R7 strobe after capture", 32'(wr_stb), 1);
    check("R3 early write hiz", 32'(q_oe), 0);
    step(4);
    check("R3 early write hiz later", 32'(q_oe), 0);
    check("R7 single pulse", 32'(wr_stb), 0);
    we_n = 1; cas_n = 1; ras_n = 1; step(2);

    // read-modify-write
    ras_n = 0; rd_data = 4'hC; step(1);
    cas_n = 0; step(1);
    check("R2 rmw q_oe", 32'(q_oe), 1);
    din = 4'hB; we_n = 0; push_write(4'hB); step(1);
    din = 4'h1; rd_data = 4'h2; step(1);
    check("R6 rmw strobe", 32'(wr_stb), 1);
    check("R8 rmw keeps old data", 32'(q), 32'hC);
    check("R8 rmw still driven", 32'(q_oe), 1);
    step(1);
    cas_n = 1; we_n = 1; ras_n = 1; step(2);

    // late write held by sense interlock
    ras_n = 0; sense_done = 0; col_sel = 1; step(1);
    cas_n = 0; step(2);
    check("R9 no decision without sense", 32'(q_oe), 0);
    we_n = 0; din = 4'h7; push_write(4'h7); step(2);
    check("R9 strobe held without sense", 32'(wr_stb), 0);
    din = 4'h8; sense_done = 1; step(1);
    check("R9 strobe after sense", 32'(wr_stb), 1);
    step(2);
    check("R3 late write sampled low", 32'(q_oe), 0);
    cas_n = 1; we_n = 1; ras_n = 1; step(2);

    // read held by column-select interlock
    ras_n = 0; col_sel = 0; rd_data = 4'hE; step(1);
    cas_n = 0; step(2);
    check("R9 no decision without col_sel", 32'(q_oe), 0);
    col_sel = 1; step(1);
    check("R9 decision after col_sel", 32'(q_oe), 1);
    check("R2 q after col_sel", 32'(q), 32'hE);
    cas_n = 1; ras_n = 1; step(3);

    check("R7 all writes strobed", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule